// File: doc/BRIEF.md
# Check-Before-Subtract Counting Core

This block is a small processor that runs programs built from a single four-operand instruction. It works only with non-negative counts. For an instruction with operands X, Y, Z and T, it compares the word at address Y against the word at address X. If the Y word is at least as large, it writes the difference Y − X into address Z and goes on to the next instruction. If the Y word is smaller, the test fails: nothing in memory changes and control moves to address T. Because the test comes before the subtraction, no stored value can ever go below zero. The result goes to its own address Z, so both source words survive when Z is a separate location.

Programs and data share one memory of words with a single synchronous port. A testbench or host loads this memory through a preload port while the core is halted, pulses start, waits for the halted flag, and then reads results back through the same port. The program counter is visible at all times.

Top module: `cbs_core`

## Requirements
- R1: After reset the core is halted (halted = 1) and pc = 0.
- R2: A start pulse while halted begins execution at address 0: one cycle later halted = 0 and pc = 0.
- R3: An instruction at address P is laid out as Mem[P] = X, Mem[P+1] = Y, Mem[P+2] = Z, Mem[P+3] = T. When Mem[Y] ≥ Mem[X], the core writes Mem[Y] − Mem[X] into Mem[Z] and continues at P + 4.
- R4: Equal operands count as a passed test: Mem[Z] becomes 0 and execution continues at P + 4.
- R5: When Mem[Y] < Mem[X], no memory word is written and execution continues at T.
- R6: A failed test with T = 0xFFFF halts the core; pc keeps the address of that instruction, and it stays constant while halted.
- R7: The core halts without executing if an instruction fetch would reach past the last word (P + 3 > 255), or if X, Y or Z is not below 256. pc then holds the offending instruction address.
- R8: The compare and subtract are unsigned 16-bit: a word with bit 15 set counts as larger than any smaller-valued word.
- R9: When Z differs from X and Y, the two source words keep their values.
- R10: While halted, asserting ld_en with ld_we = 1 writes ld_wdata at ld_addr, and ld_en with ld_we = 0 returns the word at ld_addr on ld_rdata one cycle later. While running, the preload port has no effect on memory.
- R11: A preload write in the same cycle as the start pulse reaches memory before the first instruction fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse while halted to run from address 0 |
| halted | output | 1 | High while the core is stopped |
| pc | output | 16 | Address of the current instruction |
| ld_en | input | 1 | Preload port enable (effective only while halted) |
| ld_we | input | 1 | Preload write strobe |
| ld_addr | input | 8 | Preload word address |
| ld_wdata | input | 16 | Preload write data |
| ld_rdata | output | 16 | Memory word read one cycle after ld_addr |

## Verification
The core's own start and the preload port's write can land in the same clock cycle, because both act while the core is still halted. The bench provokes this by changing the Z operand of the first instruction with a preload write in the very cycle that carries the start pulse. It then judges which Z the core used by reading back both candidate destination words after the halt. A second case drives preload writes while a counting loop runs, and confirms afterwards that the target word still holds its original value.

// File: rtl/cbs_pkg.sv
// Package: shared widths and sequencer states for the check-before-subtract core.
// Assumes 16-bit words and a power-of-two memory depth.
package cbs_pkg;
    localparam int WORD_W    = 16;
    localparam int MEM_WORDS = 256;
    localparam int ADDR_W    = $clog2(MEM_WORDS);

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_OPX   = 3'd1,
        ST_OPY   = 3'd2,
        ST_OPZ   = 3'd3,
        ST_OPT   = 3'd4,
        ST_RDX   = 3'd5,
        ST_RDY   = 3'd6,
        ST_EXEC  = 3'd7
    } seq_state_t;
endpackage

// File: rtl/cbs_mem.sv
// Module: single-port synchronous word memory.
// Read data appears one cycle after the address; a write returns the old word.
module cbs_mem #(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    // Purpose: write on strobe and register the addressed word.
    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        rdata <= store[addr];
    end
endmodule

// File: rtl/cbs_alu.sv
// Module: unsigned compare-then-subtract unit.
// Reports whether minuend >= subtrahend and the difference; difference is used only on a pass.
module cbs_alu #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] subtrahend,
    input  logic [DW-1:0] minuend,
    output logic          pass,
    output logic [DW-1:0] diff
);
    // Purpose: unsigned test and difference.
    always_comb begin
        pass = (minuend >= subtrahend);
        diff = minuend - subtrahend;
    end

    // Purpose: a passing subtraction never wraps below zero (R8).
    always_comb begin
        if (pass) begin
            assert_no_wrap_R8: assert (diff <= minuend);
        end
    end
endmodule

// File: rtl/cbs_seq.sv
// Module: instruction sequencer. Fetches X, Y, Z, T, reads Mem[X] and Mem[Y],
// then writes the difference or branches. Assumes one-cycle memory read latency.
module cbs_seq
    import cbs_pkg::*;
#(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] mem_rdata,
    input  logic          alu_pass,
    input  logic [DW-1:0] alu_diff,
    output logic [AW-1:0] mem_addr,
    output logic          mem_we,
    output logic [DW-1:0] mem_wdata,
    output logic [DW-1:0] sub_val,
    output logic          halted,
    output logic [DW-1:0] pc
);
    localparam logic [DW-1:0] LAST_PC  = DW'(DEPTH - 4);
    localparam logic [DW-1:0] TOP_ADDR = DW'(DEPTH);
    localparam logic [DW-1:0] STOP_T   = '1;

    seq_state_t    state;
    logic [DW-1:0] op_x, op_y, op_z, op_t;
    logic [DW-1:0] val_x;
    logic          opnd_bad;

    assign halted  = (state == ST_IDLE);
    assign sub_val = val_x;

    // Purpose: operand addresses must fall inside memory.
    always_comb begin
        opnd_bad = (op_x >= TOP_ADDR) || (op_y >= TOP_ADDR) || (op_z >= TOP_ADDR);
    end

    // Purpose: drive the memory port from the current step.
    always_comb begin
        mem_we    = 1'b0;
        mem_wdata = alu_diff;
        unique case (state)
            ST_OPX:  mem_addr = pc[AW-1:0];
            ST_OPY:  mem_addr = AW'(pc + DW'(1));
            ST_OPZ:  mem_addr = AW'(pc + DW'(2));
            ST_OPT:  mem_addr = AW'(pc + DW'(3));
            ST_RDX:  mem_addr = op_x[AW-1:0];
            ST_RDY:  mem_addr = op_y[AW-1:0];
            ST_EXEC: begin
                mem_addr = op_z[AW-1:0];
                mem_we   = alu_pass;
            end
            default: mem_addr = '0;
        endcase
    end

    // Purpose: step the sequencer and capture operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pc    <= '0;
            op_x  <= '0;
            op_y  <= '0;
            op_z  <= '0;
            op_t  <= '0;
            val_x <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        pc    <= '0;
                        state <= ST_OPX;
                    end
                end
                ST_OPX:  state <= (pc > LAST_PC) ? ST_IDLE : ST_OPY;
                ST_OPY: begin
                    op_x  <= mem_rdata;
                    state <= ST_OPZ;
                end
                ST_OPZ: begin
                    op_y  <= mem_rdata;
                    state <= ST_OPT;
                end
                ST_OPT: begin
                    op_z  <= mem_rdata;
                    state <= ST_RDX;
                end
                ST_RDX: begin
                    op_t  <= mem_rdata;
                    state <= opnd_bad ? ST_IDLE : ST_RDY;
                end
                ST_RDY: begin
                    val_x <= mem_rdata;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (alu_pass) begin
                        pc    <= pc + DW'(4);
                        state <= ST_OPX;
                    end else if (op_t == STOP_T) begin
                        state <= ST_IDLE;
                    end else begin
                        pc    <= op_t;
                        state <= ST_OPX;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: start from halt enters the first fetch at address 0.
    assert_start_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && start) |=> (!halted && pc == '0));

    // Purpose: a passed test advances by one instruction.
    assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && alu_pass) |=> (pc == $past(pc) + DW'(4)));

    // Purpose: a failed test with a real target lands on that target.
    assert_branch_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && !alu_pass && op_t != STOP_T) |=> (pc == $past(op_t)));

    // Purpose: a halted core stays put until started.
    assert_halt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> (halted && $stable(pc)));
endmodule

// File: rtl/cbs_core.sv
// Module: top of the check-before-subtract core. Shares one memory port between
// the sequencer (while running) and the preload port (while halted).
module cbs_core #(
    parameter int DW    = 16,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          halted,
    output logic [DW-1:0] pc,
    input  logic          ld_en,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_wdata,
    output logic [DW-1:0] ld_rdata
);
    logic [AW-1:0] seq_addr, m_addr;
    logic          seq_we, m_we;
    logic [DW-1:0] seq_wdata, m_wdata, m_rdata;
    logic [DW-1:0] sub_val, alu_diff;
    logic          alu_pass;

    // Purpose: grant the memory port to the preload side only while halted.
    always_comb begin
        if (halted) begin
            m_addr  = ld_addr;
            m_we    = ld_en && ld_we;
            m_wdata = ld_wdata;
        end else begin
            m_addr  = seq_addr;
            m_we    = seq_we;
            m_wdata = seq_wdata;
        end
    end

    assign ld_rdata = m_rdata;

    cbs_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .addr  (m_addr),
        .we    (m_we),
        .wdata (m_wdata),
        .rdata (m_rdata)
    );

    cbs_alu #(.DW(DW)) u_alu (
        .subtrahend (sub_val),
        .minuend    (m_rdata),
        .pass       (alu_pass),
        .diff       (alu_diff)
    );

    cbs_seq #(.DW(DW), .DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .mem_rdata (m_rdata),
        .alu_pass  (alu_pass),
        .alu_diff  (alu_diff),
        .mem_addr  (seq_addr),
        .mem_we    (seq_we),
        .mem_wdata (seq_wdata),
        .sub_val   (sub_val),
        .halted    (halted),
        .pc        (pc)
    );

    // Purpose: a write while running comes only from the sequencer (R10).
    assert_run_write_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && m_we) |-> (m_addr == seq_addr && m_wdata == alu_diff));
endmodule

// File: tb/test_cbs_core.sv
`timescale 1ns/1ps
// Bench: scoreboard of expected memory words, drained through the preload port.
module test_cbs_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        halted;
    logic [15:0] pc;
    logic        ld_en = 1'b0;
    logic        ld_we = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [15:0] ld_wdata = '0;
    logic [15:0] ld_rdata;

    int checks = 0;
    int failures = 0;

    typedef struct {
        int          addr;
        logic [15:0] val;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    cbs_core i_cbs_core (
        .clk(clk), .rst_n(rst_n), .start(start), .halted(halted), .pc(pc),
        .ld_en(ld_en), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_wdata(ld_wdata), .ld_rdata(ld_rdata)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_we = 1'b1; ld_addr = 8'(a); ld_wdata = d;
        @(negedge clk);
        ld_en = 1'b0; ld_we = 1'b0;
    endtask

    task automatic instr(input int p, input int x, input int y, input int z, input int t);
        poke(p,     16'(x));
        poke(p + 1, 16'(y));
        poke(p + 2, 16'(z));
        poke(p + 3, 16'(t));
    endtask

    // Driver side: push an expected word.
    task automatic expect_word(input int a, input logic [15:0] v, input string tag);
        exp_t e;
        e.addr = a; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor side: pop each expectation and compare with a read-back.
    task automatic drain();
        exp_t e;
        while (sb.size() > 0) begin
            e = sb.pop_front();
            @(negedge clk);
            ld_en = 1'b1; ld_we = 1'b0; ld_addr = 8'(e.addr);
            @(negedge clk);
            ld_en = 1'b0;
            check(e.tag, ld_rdata, e.val);
        end
    endtask

    task automatic run_prog();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_halt(input string tag);
        int n = 0;
        while (!halted && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check({tag, " halted"}, 16'(halted), 16'd1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 halted after reset", 16'(halted), 16'd1);
        check("R1 pc after reset", pc, 16'd0);

        // Program 1: pass then fail-halt (R3, R6, R9)
        instr(0, 20, 21, 22, 16'hFFFF);
        instr(4, 21, 20, 23, 16'hFFFF);
        poke(20, 16'd5); poke(21, 16'd12); poke(22, 16'h0000); poke(23, 16'hAAAA);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 running after start", 16'(halted), 16'd0);
        check("R2 pc after start", pc, 16'd0);
        wait_halt("R6 p1");
        check("R6 pc at halting instr", pc, 16'd4);
        repeat (5) @(negedge clk);
        check("R6 pc stable while halted", pc, 16'd4);
        expect_word(22, 16'd7, "R3 difference written");
        expect_word(23, 16'hAAAA, "R5 no write on fail");
        expect_word(20, 16'd5, "R9 source X kept");
        expect_word(21, 16'd12, "R9 source Y kept");
        drain();

        // Program 2: branch, skipped instr, equality (R4, R5)
        instr(0, 30, 31, 32, 8);
        instr(4, 30, 30, 33, 16'hFFFF);
        instr(8, 31, 31, 34, 16'hFFFF);
        instr(12, 30, 31, 35, 16'hFFFF);
        poke(30, 16'd9); poke(31, 16'd3); poke(32, 16'h1111);
        poke(33, 16'h2222); poke(34, 16'h7777); poke(35, 16'h6666);
        run_prog();
        wait_halt("R5 p2");
        check("R5 pc after branch path", pc, 16'd12);
        expect_word(32, 16'h1111, "R5 failed test writes nothing");
        expect_word(33, 16'h2222, "R5 skipped instruction not run");
        expect_word(34, 16'h0000, "R4 equal gives zero");
        expect_word(35, 16'h6666, "R5 final fail no write");
        drain();

        // Program 3: unsigned compare (R8)
        instr(0, 40, 41, 42, 16'hFFFF);
        instr(4, 41, 40, 43, 16'hFFFF);
        poke(40, 16'd1); poke(41, 16'h8000); poke(42, 16'h0000); poke(43, 16'h3333);
        run_prog();
        wait_halt("R8 p3");
        check("R8 pc", pc, 16'd4);
        expect_word(42, 16'h7FFF, "R8 unsigned difference");
        expect_word(43, 16'h3333, "R8 small minus large fails");
        drain();

        // Program 4: branch to a fetch past the top (R7)
        instr(0, 50, 50, 51, 16'hFFFF);
        instr(4, 52, 50, 53, 254);
        poke(50, 16'd0); poke(51, 16'h9999); poke(52, 16'd1); poke(53, 16'h4242);
        run_prog();
        wait_halt("R7 p4");
        check("R7 pc at out-of-range fetch", pc, 16'd254);
        expect_word(51, 16'h0000, "R4 zero minus zero");
        expect_word(53, 16'h4242, "R7 no write");
        drain();

        // Program 5: operand address out of range (R7)
        instr(0, 300, 50, 51, 16'hFFFF);
        poke(51, 16'h4444);
        run_prog();
        wait_halt("R7 p5");
        check("R7 pc at bad operand", pc, 16'd0);
        expect_word(51, 16'h4444, "R7 bad operand no write");
        drain();

        // Program 6: counting loop, preload writes while running (R10)
        instr(0, 62, 63, 63, 16'hFFFF);
        instr(4, 62, 60, 61, 0);
        poke(60, 16'd0); poke(61, 16'h0000); poke(62, 16'd1); poke(63, 16'd20);
        poke(70, 16'h5555);
        run_prog();
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_we = 1'b1; ld_addr = 8'd70; ld_wdata = 16'hDEAD;
        end
        @(negedge clk);
        ld_en = 1'b0; ld_we = 1'b0;
        wait_halt("R10 p6");
        check("R10 loop pc", pc, 16'd0);
        expect_word(70, 16'h5555, "R10 preload ignored while running");
        expect_word(63, 16'h0000, "R3 counter reached zero");
        expect_word(61, 16'h9999 & 16'h0000, "R5 loop branch no write");
        drain();

        // Program 7: preload write in the start cycle (R11)
        instr(0, 80, 81, 81, 16'hFFFF);
        instr(4, 81, 80, 83, 16'hFFFF);
        poke(80, 16'd1); poke(81, 16'd5); poke(82, 16'h0000); poke(83, 16'h1234);
        @(negedge clk);
        start = 1'b1;
        ld_en = 1'b1; ld_we = 1'b1; ld_addr = 8'd2; ld_wdata = 16'd82;
        @(negedge clk);
        start = 1'b0; ld_en = 1'b0; ld_we = 1'b0;
        wait_halt("R11 p7");
        expect_word(82, 16'd4, "R11 new Z used");
        expect_word(81, 16'd5, "R11 old Z untouched");
        expect_word(2, 16'd82, "R11 operand word stored");
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule